// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs clause-22 style management transactions to an external PHY over a two-wire clock/data link. A command holds the direction (read or write), a 5-bit PHY address, a register address and 16 bits of write data. The command is taken on a one-cycle start strobe. The block generates the management clock from a divider that is set at run time. It drives the data line and its output enable, and it samples the returned data line during reads. When the transaction ends it gives a one-cycle completion pulse, and for a read it also presents the 16 captured data bits.

Each transaction begins with 33 driven ones as a preamble. For a read, a 16-bit header follows. The block then releases the line and clocks 19 input bits: two turnaround bits, 16 data bits and one trailing idle bit. Only the data bits are kept. For a write, a 32-bit frame follows, which carries the turnaround pattern and the data, and then two clocks with the line released. A register address above 31 never reaches the line. Such a request finishes at once, and if it was a read it reports all ones.

Software has to set the divider so that each half period of the management clock lasts at least 200 ns, which keeps the clock at or below 2.5 MHz. With a 100 MHz system clock this means a half-period count of 20 or more.

Top module: `mdio_master`

## Requirements
- R1: While no transaction is in progress, `mdc` is low, `mdio_oe` is low and `busy` is low. This is also the state after reset.
- R2: Each high or low half of `mdc` lasts exactly `half_div` system clock cycles. A value of 0 is treated as 1.
- R3: Every accepted transaction starts with 33 rising edges of `mdc` during which `mdio_oe`=1 and `mdio_o`=1.
- R4: A read then drives 16 bits, most significant first, over 16 rising edges: 1,1,0,1,1,0, then `phy_addr[4:0]`, then `reg_addr[4:0]`.
- R5: A write then drives 32 bits, most significant first: 0,1,0,1, then `phy_addr[4:0]`, then `reg_addr[4:0]`, then 1,0, then `wdata[15:0]`.
- R6: After its header, a read releases the line (`mdio_oe`=0) for 19 rising edges. `rdata` becomes the 16 values sampled before edges 3 to 18 of that group, first sample in bit 15. The samples before edges 1, 2 and 19 are discarded.
- R7: After its frame, a write releases the line for exactly 2 rising edges, and only then completes. `rdata` keeps its value across a write.
- R8: A request whose `reg_addr` is above 31 produces no `mdc` edge and never enables the output. `done` rises two cycles after the strobe cycle. For a read in this case, `rdata` becomes 16'hFFFF.
- R9: `mdio_o` and `mdio_oe` change only while `mdc` is low. Input is sampled on the system clock edge that raises `mdc`.
- R10: `busy` is high from the cycle after an accepted start until `done`. A `start` that arrives while `busy` is high is ignored.
- R11: `done` is a one-cycle pulse, and it appears in the same cycle as `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| wr_req | input | 1 | 1 = write, 0 = read |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 6 | Register address; values above 31 are rejected |
| wdata | input | 16 | Write data |
| half_div | input | 8 | System cycles per management clock half period |
| mdio_i | input | 1 | Sampled data line |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Completion pulse |
| rdata | output | 16 | Read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Driven data value |
| mdio_oe | output | 1 | Data line output enable |

## Verification
Several rules are checked by assertions on every cycle: the idle line state, data that stays stable while `mdc` is high, a line that is released during the read and write tail phases, silence on the line during a rejected request, and the shape of the `done` pulse together with the fall of `busy`. Other behaviour can only be shown by the bench's scenarios, because each depends on a whole sequence of edges. These are the bit-exact contents of the preamble, header and frame, the edge count of each phase, the half-period length at several divider settings, the choice of data window when the framing bits the PHY returns are flipped, and the discarding of a strobe that arrives mid-transaction.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 33;
    localparam int RDHDR_BITS = 16;
    localparam int WRFRM_BITS = 32;
    localparam int RX_BITS    = 19;
    localparam int WRTL_BITS  = 2;
    localparam int DATA_W     = 16;
    localparam int PHY_W      = 5;
    localparam int CNT_W      = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SEND,
        PH_RECV,
        PH_TAIL,
        PH_ABORT
    } mdio_phase_e;

    typedef struct packed {
        mdio_phase_e        phase;
        logic [CNT_W-1:0]   cnt;
        logic [31:0]        frame;
        logic               mdc;
        logic               oe;
        logic               dout;
        logic               busy;
        logic               done;
        logic               rd;
        logic [DATA_W-1:0]  rdata;
    } mdio_state_t;

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             half_end
);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim_m1;

    always_comb begin
        lim_m1   = (half_div == '0) ? '0 : half_div - 1'b1;
        half_end = run && (cnt_q >= lim_m1);
        if (!run || half_end) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_end && $stable(half_div) && (lim_m1 != '0) |=> !half_end);

endmodule

// File: rtl/mdio_capture.sv
module mdio_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [DATA_W-1:0] data
);

    logic [DATA_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_en) sh_d = {sh_q[DATA_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign data = sh_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int REG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_req,
    input  logic [PHY_W-1:0]  phy_addr,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_BITS - 1);
    localparam logic [CNT_W-1:0] RDH_LAST  = CNT_W'(RDHDR_BITS - 1);
    localparam logic [CNT_W-1:0] WRF_LAST  = CNT_W'(WRFRM_BITS - 1);
    localparam logic [CNT_W-1:0] RX_LAST   = CNT_W'(RX_BITS - 1);
    localparam logic [CNT_W-1:0] TL_LAST   = CNT_W'(WRTL_BITS - 1);
    localparam logic [CNT_W-1:0] WIN_HI    = CNT_W'(DATA_W);

    mdio_state_t       s_d, s_q;
    logic              half_end;
    logic              shift_en;
    logic              run;
    logic              addr_bad;
    logic [DATA_W-1:0] cap_data;

    assign run      = s_q.busy && (s_q.phase != PH_ABORT);
    assign addr_bad = 32'(reg_addr) > 32'd31;

    mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_div (half_div),
        .half_end (half_end)
    );

    mdio_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (mdio_i),
        .data     (cap_data)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        shift_en = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.busy = 1'b1;
                    s_d.rd   = !wr_req;
                    if (addr_bad) begin
                        s_d.phase = PH_ABORT;
                    end else begin
                        s_d.phase = PH_PRE;
                        s_d.cnt   = PRE_LAST;
                        s_d.oe    = 1'b1;
                        s_d.dout  = 1'b1;
                        if (wr_req)
                            s_d.frame = {4'b0101, phy_addr, reg_addr[4:0], 2'b10, wdata};
                        else
                            s_d.frame = {6'b110110, phy_addr, reg_addr[4:0], 16'h0000};
                    end
                end
            end
            PH_ABORT: begin
                s_d.phase = PH_IDLE;
                s_d.busy  = 1'b0;
                s_d.done  = 1'b1;
                if (s_q.rd) s_d.rdata = '1;
            end
            default: begin
                if (half_end) begin
                    if (!s_q.mdc) begin
                        s_d.mdc = 1'b1;
                        if (s_q.phase == PH_RECV && s_q.cnt >= 1 && s_q.cnt <= WIN_HI)
                            shift_en = 1'b1;
                    end else begin
                        s_d.mdc = 1'b0;
                        if (s_q.cnt != '0) begin
                            s_d.cnt = s_q.cnt - 1'b1;
                            if (s_q.phase == PH_SEND) begin
                                s_d.frame = {s_q.frame[30:0], 1'b0};
                                s_d.dout  = s_q.frame[30];
                            end
                        end else begin
                            case (s_q.phase)
                                PH_PRE: begin
                                    s_d.phase = PH_SEND;
                                    s_d.cnt   = s_q.rd ? RDH_LAST : WRF_LAST;
                                    s_d.dout  = s_q.frame[31];
                                end
                                PH_SEND: begin
                                    s_d.phase = s_q.rd ? PH_RECV : PH_TAIL;
                                    s_d.cnt   = s_q.rd ? RX_LAST : TL_LAST;
                                    s_d.oe    = 1'b0;
                                    s_d.dout  = 1'b0;
                                end
                                default: begin
                                    s_d.phase = PH_IDLE;
                                    s_d.busy  = 1'b0;
                                    s_d.done  = 1'b1;
                                    if (s_q.rd) s_d.rdata = cap_data;
                                end
                            endcase
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, frame: '0, mdc: 1'b0, oe: 1'b0,
                     dout: 1'b0, busy: 1'b0, done: 1'b0, rd: 1'b0, rdata: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign rdata   = s_q.rdata;
    assign mdc     = s_q.mdc;
    assign mdio_o  = s_q.dout;
    assign mdio_oe = s_q.oe;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc && !mdio_oe);

    // R9
    hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc && $past(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));

    // R6
    released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_RECV || s_q.phase == PH_TAIL) |-> !mdio_oe);

    // R8
    abort_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_ABORT) |-> !mdc && !mdio_oe && !half_end);

    // R10
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr_req = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic [7:0]  half_div = 8'd1;
    logic        mdio_i = 1'b1;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int          edges;
        logic [67:0] oe_map;
        logic [67:0] dat_map;
        logic [15:0] rdata;
        int          period;
    } item_t;
    item_t sb_q[$];

    logic [18:0] resp = '0;
    logic [67:0] got_oe, got_dat;
    int          edge_cnt = 0;
    int          last_rise = 0;
    int          cur_period = 2;
    bit          per_bad = 0;
    logic        mdc_prev = 1'b0;
    logic        busy_prev = 1'b0;
    logic        done_prev = 1'b0;
    logic [15:0] last_rd = '0;

    mdio_master u_mdio_master (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_req(wr_req),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .half_div(half_div), .mdio_i(mdio_i), .busy(busy), .done(done),
        .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // PHY side: records every rising edge, drives the read response
    always @(negedge clk) begin
        if (busy && !busy_prev) begin
            edge_cnt = 0;
            per_bad  = 0;
            got_oe   = '0;
            got_dat  = '0;
        end
        if (mdc && !mdc_prev) begin
            if (edge_cnt > 0 && (cyc - last_rise) != cur_period) per_bad = 1;
            last_rise = cyc;
            if (edge_cnt < 68) begin
                got_oe[edge_cnt]  = mdio_oe;
                got_dat[edge_cnt] = mdio_o;
            end
            edge_cnt = edge_cnt + 1;
            if (edge_cnt >= 49 && edge_cnt <= 67) mdio_i = resp[18 - (edge_cnt - 49)];
        end
        mdc_prev  = mdc;
        busy_prev = busy;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (done) begin
            check(!busy, "R11", "busy low with done", 68'(busy), 68'd0);
            if (sb_q.size() == 0) begin
                check(0, "R10", "unexpected completion", 68'd1, 68'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(edge_cnt == it.edges, "R3", "edge count",
                      68'(edge_cnt), 68'(it.edges));
                check(got_oe == it.oe_map, "R6", "enable map", got_oe, it.oe_map);
                check((got_dat & it.oe_map) == it.dat_map, "R4", "driven bits",
                      got_dat & it.oe_map, it.dat_map);
                check(rdata == it.rdata, "R7", "rdata", 68'(rdata), 68'(it.rdata));
                if (it.edges > 0)
                    check(!per_bad, "R2", "mdc period", 68'(per_bad), 68'd0);
            end
        end
        if (done_prev && done) check(0, "R11", "done width", 68'd2, 68'd1);
        done_prev = done;
    end

    task automatic run_txn(input bit wr, input logic [4:0] pa, input logic [5:0] ra,
                           input logic [15:0] data, input bit flip,
                           input logic [7:0] hd, input bit poke);
        item_t it;
        logic [15:0] hdr;
        logic [31:0] frm;
        it.oe_map  = '0;
        it.dat_map = '0;
        it.period  = (hd == 0) ? 2 : 2 * int'(hd);
        hdr = {6'b110110, pa, ra[4:0]};
        frm = {4'b0101, pa, ra[4:0], 2'b10, data};
        if (ra > 6'd31) begin
            it.edges = 0;
            it.rdata = wr ? last_rd : 16'hFFFF;
        end else if (!wr) begin
            it.edges = 68;
            it.rdata = data;
            for (int e = 0; e < 49; e++) begin
                it.oe_map[e]  = 1'b1;
                it.dat_map[e] = (e < 33) ? 1'b1 : hdr[15 - (e - 33)];
            end
        end else begin
            it.edges = 67;
            it.rdata = last_rd;
            for (int e = 0; e < 65; e++) begin
                it.oe_map[e]  = 1'b1;
                it.dat_map[e] = (e < 33) ? 1'b1 : frm[31 - (e - 33)];
            end
        end
        sb_q.push_back(it);
        @(negedge clk);
        cur_period = it.period;
        resp     = flip ? {2'b01, data, 1'b0} : {2'b10, data, 1'b1};
        wr_req   = wr;
        phy_addr = pa;
        reg_addr = ra;
        wdata    = data;
        half_div = hd;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R10", "busy after start", 68'(busy), 68'd1);
        if (ra > 6'd31) begin
            @(negedge clk);
            check(done, "R8", "abort completes at once", 68'(done), 68'd1);
        end
        if (poke) begin
            repeat (60) @(negedge clk);
            wr_req   = 1'b1;
            reg_addr = 6'd3;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        last_rd = it.rdata;
        @(negedge clk);
        check(!mdc && !mdio_oe && !busy, "R1", "idle between transactions",
              68'({mdc, mdio_oe, busy}), 68'd0);
    endtask

    initial begin : watchdog
        while (cyc < 150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        check(!mdc && !mdio_oe && !busy && !done, "R1", "reset state",
              68'({mdc, mdio_oe, busy, done}), 68'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 R6 read, normal turnaround response
        run_txn(1'b0, 5'h01, 6'd2, 16'hA5C3, 1'b0, 8'd1, 1'b0);
        // R6 read with flipped framing bits: window must ignore them
        run_txn(1'b0, 5'h1F, 6'd31, 16'h8001, 1'b1, 8'd2, 1'b0);
        // R5 R7 write
        run_txn(1'b1, 5'h0A, 6'd4, 16'h01E1, 1'b0, 8'd3, 1'b0);
        // R2 divider 0 acts as 1
        run_txn(1'b1, 5'h15, 6'd0, 16'hFFFF, 1'b0, 8'd0, 1'b0);
        // R8 read abort
        run_txn(1'b0, 5'h02, 6'd40, 16'h0000, 1'b0, 8'd1, 1'b0);
        run_txn(1'b0, 5'h03, 6'd7, 16'h1234, 1'b0, 8'd1, 1'b0);
        // R8 write abort leaves rdata
        run_txn(1'b1, 5'h03, 6'd33, 16'h5555, 1'b0, 8'd1, 1'b0);
        // R10 strobe during busy ignored, 2.5 MHz setting
        run_txn(1'b0, 5'h00, 6'd1, 16'h796D, 1'b0, 8'd20, 1'b1);
        repeat (200) @(negedge clk);
        check(sb_q.size() == 0 && !busy && !mdc, "R10", "no extra transaction",
              68'(sb_q.size()), 68'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule